// File: doc/BRIEF.md
# FIFO threshold and status controller

This block sits between a register bus and a serial shift engine. It holds two word FIFOs, one for transmit and one for receive, each 32 entries deep by default. A bus write to the data address queues a word for transmit, and the engine pulls those words out one at a time. Words that the engine assembles are pushed into the receive FIFO, and bus reads of the data address remove them in arrival order.

The status word gives a live view of both FIFOs: fill levels, not-full and not-empty flags, an engine busy mirror, and three sticky error flags (transmit underrun, receive overrun, bit-count error) that software clears by writing ones. Software sets a watermark for each FIFO. When a FIFO passes its watermark, a service condition is raised. That condition can drive a DMA request line when its enable is set, and it is also one of the sources for the single masked interrupt output.

Top module: `fifo_status_hub`

## Requirements
- R1: After reset, the control and enable registers read 0, both FIFOs are empty, the status word reads 0x40 (only transmit-not-full set, with the busy input low), and irq, txDmaReq and rxDmaReq are low.
- R2: Words written to address 2 reach engTxData in write order, one per engTxPop cycle. A write while the transmit FIFO is full, with no pull in that cycle, is dropped.
- R3: Reads of address 2 return received words in push order and remove them. A read of address 2 while the receive FIFO is empty returns 0 and changes no state.
- R4: Status bit 6 is transmit-not-full. Bits 11:7 hold the transmit free-slot count, with 32 free slots encoded as 0.
- R5: Status bit 14 is receive-not-empty. Bits 19:15 hold the receive occupancy minus one, and read 0 when the FIFO is empty.
- R6: Sticky flags are bit 12 (set by engTxPop on an empty transmit FIFO, which then outputs 0), bit 20 (set by a push into a full receive FIFO, and the word is dropped) and bit 21 (set by engBitErr). Writing 1 to address 3 at a flag's bit clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R7: An engine push and a bus read of address 2 in the same cycle on a full receive FIFO both succeed: the occupancy stays at 32 and the overrun flag is not set.
- R8: Control register (address 0) layout: bits 4:0 hold the transmit watermark code and bits 9:5 hold the receive watermark code. The effective watermark is the code plus one. Transmit service is active when free slots ≥ the transmit watermark. Receive service is active when occupancy ≥ the receive watermark. The register reads back what was written in bits 11:0.
- R9: txDmaReq equals control bit 10 AND transmit service. rxDmaReq equals control bit 11 AND receive service.
- R10: irq is the OR of the conditions whose enable bit (address 1) is set: bit 1 = engRxTimeout, bit 2 = receive service, bit 3 = transmit service, bit 4 = overrun flag, bit 5 = underrun flag, bit 6 = bit-count flag.
- R11: Status bit 0 mirrors engBusy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Word address: 0 control, 1 enables, 2 data, 3 status |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops the receive FIFO at address 2) |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for the addressed register, combinational |
| engTxPop | input | 1 | Engine takes the head transmit word |
| engTxData | output | DATA_W | Head transmit word, 0 when empty |
| engRxPush | input | 1 | Engine delivers a received word |
| engRxData | input | DATA_W | Received word |
| engBusy | input | 1 | Engine busy indication |
| engBitErr | input | 1 | Bit-count error pulse from the engine |
| engRxTimeout | input | 1 | Receive inactivity condition from the engine |
| irq | output | 1 | Masked interrupt request |
| txDmaReq | output | 1 | Transmit DMA service request |
| rxDmaReq | output | 1 | Receive DMA service request |

## Verification
Two events can land in the same cycle on a full receive FIFO: an engine push and a bus pop. The bench fills the receive FIFO to 32 entries, clears the overrun flag, and then raises engRxPush and a read of address 2 together. The popped word is compared against the head of the receive scoreboard queue, and the new word is appended to that queue. The status word must then show a receive level code of 31 with the overrun flag clear, and the remaining 32 reads must drain in order. A second collision is tested in the same way: an underrun set and a write-one clear of that flag in one cycle, after which the flag must read as set.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_IEN  = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_STAT = 2'd3
  } regAddr_t;

  // qualified FIFO strobes, control -> datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobe_t;

  localparam int IE_RXTO  = 1;
  localparam int IE_RXSVC = 2;
  localparam int IE_TXSVC = 3;
  localparam int IE_ROR   = 4;
  localparam int IE_TUR   = 5;
  localparam int IE_BCE   = 6;
  localparam int IE_W     = 7;

endpackage

// File: rtl/xfs_ring.sv
module xfs_ring #(
  parameter  int W     = 32,
  parameter  int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);

  // R2: control never pushes a full ring without a matching pop
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> !full);

  // R3: control never pops an empty ring
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

  // R5: occupancy moves by one per accepted push
  a_r5_count_up: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> count == $past(count) + CNT_W'(1));

  a_r5_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push) |=> count == $past(count) - CNT_W'(1));

endmodule

// File: rtl/xfs_dp.sv
module xfs_dp
  import xfs_pkg::*;
#(
  parameter  int W     = 32,
  parameter  int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strb,
  input  logic [W-1:0]     txWord,
  input  logic [W-1:0]     rxWord,
  output logic [W-1:0]     txHead,
  output logic [W-1:0]     rxHead,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxEmpty
);

  // channel 0 = transmit, channel 1 = receive
  logic [1:0]       pushV, popV, fullV, emptyV;
  logic [W-1:0]     pushD [2];
  logic [W-1:0]     headD [2];
  logic [CNT_W-1:0] cntV  [2];

  assign pushV    = {strb.rxPush, strb.txPush};
  assign popV     = {strb.rxPop,  strb.txPop};
  assign pushD[0] = txWord;
  assign pushD[1] = rxWord;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    xfs_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushV[g]),
      .pushData (pushD[g]),
      .pop      (popV[g]),
      .headData (headD[g]),
      .count    (cntV[g]),
      .full     (fullV[g]),
      .empty    (emptyV[g])
    );
  end

  assign txHead  = headD[0];
  assign rxHead  = headD[1];
  assign txCount = cntV[0];
  assign rxCount = cntV[1];
  assign txFull  = fullV[0];
  assign rxFull  = fullV[1];
  assign txEmpty = emptyV[0];
  assign rxEmpty = emptyV[1];

endmodule

// File: rtl/xfs_ctl.sv
module xfs_ctl
  import xfs_pkg::*;
#(
  parameter  int W     = 32,
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH),
  localparam int CNT_W = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [W-1:0]     regWdata,
  output logic [W-1:0]     regRdata,
  input  logic             engTxPop,
  output logic [W-1:0]     engTxData,
  input  logic             engRxPush,
  input  logic             engBusy,
  input  logic             engBitErr,
  input  logic             engRxTimeout,
  output logic             irq,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output fifoStrobe_t      strb,
  input  logic [W-1:0]     txHead,
  input  logic [W-1:0]     rxHead,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty
);

  // control register layout
  localparam int CT_RXTH_LO = LVL_W;
  localparam int CT_TXDMA   = 2 * LVL_W;
  localparam int CT_RXDMA   = 2 * LVL_W + 1;
  localparam int CT_W       = 2 * LVL_W + 2;

  // status word layout
  localparam int ST_BUSY     = 0;
  localparam int ST_TNF      = 6;
  localparam int ST_TXLVL_LO = ST_TNF + 1;
  localparam int ST_TUR      = ST_TXLVL_LO + LVL_W;
  localparam int ST_RNE      = ST_TUR + 2;
  localparam int ST_RXLVL_LO = ST_RNE + 1;
  localparam int ST_ROR      = ST_RXLVL_LO + LVL_W;
  localparam int ST_BCE      = ST_ROR + 1;

  logic [CT_W-1:0]   ctrlQ;
  logic [IE_W-1:1]   ienQ;
  logic              turQ, rorQ, bceQ;

  logic wrCtrl, wrIen, wrData, wrStat, rdData;
  logic txPopOk, rxPopOk;
  logic setTur, setRor, setBce;
  logic clrTur, clrRor, clrBce;
  logic [CNT_W-1:0] freeCnt, txMark, rxMark;
  logic [LVL_W-1:0] rxLvlCode;
  logic txSvc, rxSvc;
  logic [W-1:0] statusWord;

  // ---------------- bus decode ----------------
  assign wrCtrl = regWr && (regAddr == ADDR_CTRL);
  assign wrIen  = regWr && (regAddr == ADDR_IEN);
  assign wrData = regWr && (regAddr == ADDR_DATA);
  assign wrStat = regWr && (regAddr == ADDR_STAT);
  assign rdData = regRd && (regAddr == ADDR_DATA);

  // ---------------- FIFO strobe qualification ----------------
  assign txPopOk = engTxPop && !txEmpty;
  assign rxPopOk = rdData && !rxEmpty;

  always_comb begin
    strb.txPop  = txPopOk;
    strb.txPush = wrData && (!txFull || txPopOk);
    strb.rxPop  = rxPopOk;
    strb.rxPush = engRxPush && (!rxFull || rxPopOk);
  end

  assign engTxData = txEmpty ? '0 : txHead;

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      ienQ  <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= regWdata[CT_W-1:0];
      if (wrIen)  ienQ  <= regWdata[IE_W-1:1];
    end
  end

  // ---------------- sticky error flags ----------------
  assign setTur = engTxPop && txEmpty;
  assign setRor = engRxPush && rxFull && !rxPopOk;
  assign setBce = engBitErr;
  assign clrTur = wrStat && regWdata[ST_TUR];
  assign clrRor = wrStat && regWdata[ST_ROR];
  assign clrBce = wrStat && regWdata[ST_BCE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      turQ <= 1'b0;
      rorQ <= 1'b0;
      bceQ <= 1'b0;
    end else begin
      turQ <= setTur || (turQ && !clrTur);
      rorQ <= setRor || (rorQ && !clrRor);
      bceQ <= setBce || (bceQ && !clrBce);
    end
  end

  // ---------------- levels and watermarks ----------------
  assign freeCnt   = CNT_W'(DEPTH) - txCount;
  assign txMark    = {1'b0, ctrlQ[LVL_W-1:0]} + CNT_W'(1);
  assign rxMark    = {1'b0, ctrlQ[CT_RXTH_LO +: LVL_W]} + CNT_W'(1);
  assign txSvc     = (freeCnt >= txMark);
  assign rxSvc     = (rxCount >= rxMark);
  assign rxLvlCode = rxEmpty ? '0 : LVL_W'(rxCount - CNT_W'(1));

  assign txDmaReq = ctrlQ[CT_TXDMA] && txSvc;
  assign rxDmaReq = ctrlQ[CT_RXDMA] && rxSvc;

  assign irq = (ienQ[IE_RXTO]  && engRxTimeout) ||
               (ienQ[IE_RXSVC] && rxSvc)        ||
               (ienQ[IE_TXSVC] && txSvc)        ||
               (ienQ[IE_ROR]   && rorQ)         ||
               (ienQ[IE_TUR]   && turQ)         ||
               (ienQ[IE_BCE]   && bceQ);

  // ---------------- status word and read mux ----------------
  always_comb begin
    statusWord                         = '0;
    statusWord[ST_BUSY]                = engBusy;
    statusWord[ST_TNF]                 = !txFull;
    statusWord[ST_TXLVL_LO +: LVL_W]   = freeCnt[LVL_W-1:0];
    statusWord[ST_TUR]                 = turQ;
    statusWord[ST_RNE]                 = !rxEmpty;
    statusWord[ST_RXLVL_LO +: LVL_W]   = rxLvlCode;
    statusWord[ST_ROR]                 = rorQ;
    statusWord[ST_BCE]                 = bceQ;
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: regRdata[CT_W-1:0] = ctrlQ;
      ADDR_IEN:  regRdata[IE_W-1:1] = ienQ;
      ADDR_DATA: regRdata = rxEmpty ? '0 : rxHead;
      ADDR_STAT: regRdata = statusWord;
      default:   regRdata = '0;
    endcase
  end

  // R6: a flag holds unless its clear bit is written
  a_r6_tur_hold: assert property (@(posedge clk) disable iff (!rstN)
    (turQ && !clrTur) |=> turQ);

  // R6: a set in the same cycle as a clear wins
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxFull && !rxPopOk) |=> rorQ);

  // R7: a push matched by a pop never raises overrun
  a_r7_no_false_ror: assert property (@(posedge clk) disable iff (!rstN)
    (rxPopOk && !rorQ) |=> !rorQ);

  // R10: with no enables the interrupt stays low
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == '0) |-> !irq);

endmodule

// File: rtl/fifo_status_hub.sv
module fifo_status_hub
  import xfs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxData,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              engBusy,
  input  logic              engBitErr,
  input  logic              engRxTimeout,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoStrobe_t       strb;
  logic [DATA_W-1:0] txHead, rxHead;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic              txFull, txEmpty, rxFull, rxEmpty;

  xfs_ctl #(.W(DATA_W), .DEPTH(DEPTH)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .regAddr      (regAddr),
    .regWr        (regWr),
    .regRd        (regRd),
    .regWdata     (regWdata),
    .regRdata     (regRdata),
    .engTxPop     (engTxPop),
    .engTxData    (engTxData),
    .engRxPush    (engRxPush),
    .engBusy      (engBusy),
    .engBitErr    (engBitErr),
    .engRxTimeout (engRxTimeout),
    .irq          (irq),
    .txDmaReq     (txDmaReq),
    .rxDmaReq     (rxDmaReq),
    .strb         (strb),
    .txHead       (txHead),
    .rxHead       (rxHead),
    .txCount      (txCount),
    .rxCount      (rxCount),
    .txFull       (txFull),
    .txEmpty      (txEmpty),
    .rxFull       (rxFull),
    .rxEmpty      (rxEmpty)
  );

  xfs_dp #(.W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txWord  (regWdata),
    .rxWord  (engRxData),
    .txHead  (txHead),
    .rxHead  (rxHead),
    .txCount (txCount),
    .rxCount (rxCount),
    .txFull  (txFull),
    .txEmpty (txEmpty),
    .rxFull  (rxFull),
    .rxEmpty (rxEmpty)
  );

endmodule

// File: tb/fifo_status_hub_test.sv
`timescale 1ns/1ps
module fifo_status_hub_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        engTxPop = 1'b0;
  logic [31:0] engTxData;
  logic        engRxPush = 1'b0;
  logic [31:0] engRxData = '0;
  logic        engBusy = 1'b0;
  logic        engBitErr = 1'b0;
  logic        engRxTimeout = 1'b0;
  logic        irq, txDmaReq, rxDmaReq;

  int nChk = 0;
  int nBad = 0;

  logic [31:0] txQ[$];
  logic [31:0] rxQ[$];
  logic [11:0] mCtrl = '0;
  logic [6:0]  mIen  = '0;
  logic        mTur = 1'b0, mRor = 1'b0, mBce = 1'b0;

  always #2.5 clk = ~clk;

  fifo_status_hub uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .engTxPop(engTxPop),
    .engTxData(engTxData), .engRxPush(engRxPush), .engRxData(engRxData),
    .engBusy(engBusy), .engBitErr(engBitErr), .engRxTimeout(engRxTimeout),
    .irq(irq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected words as the design produces them
  always @(negedge clk) begin
    if (rstN) begin
      if (engTxPop) begin
        logic [31:0] e;
        e = (txQ.size() != 0) ? txQ.pop_front() : 32'h0;
        chk("R2 tx word order", engTxData, e);
      end
      if (regRd && regAddr == 2'd2) begin
        logic [31:0] e;
        e = (rxQ.size() != 0) ? rxQ.pop_front() : 32'h0;
        chk("R3 rx word order", regRdata, e);
      end
    end
  end

  function automatic logic [31:0] expStatus();
    logic [31:0] s;
    int free, occ;
    free = 32 - txQ.size();
    occ  = rxQ.size();
    s = '0;
    s[0]     = engBusy;
    s[6]     = (free != 0);
    s[11:7]  = free[4:0];
    s[12]    = mTur;
    s[14]    = (occ != 0);
    s[19:15] = (occ != 0) ? 5'(occ - 1) : 5'd0;
    s[20]    = mRor;
    s[21]    = mBce;
    return s;
  endfunction

  // status, DMA and interrupt outputs against the model
  task automatic checkAll(string tag);
    logic txSvc, rxSvc, irqE;
    regAddr = 2'd3;
    @(negedge clk);
    txSvc = (32 - txQ.size()) >= (int'(mCtrl[4:0]) + 1);
    rxSvc = rxQ.size() >= (int'(mCtrl[9:5]) + 1);
    irqE  = (mIen[1] & engRxTimeout) | (mIen[2] & rxSvc) | (mIen[3] & txSvc) |
            (mIen[4] & mRor) | (mIen[5] & mTur) | (mIen[6] & mBce);
    chk({tag, " status R4 R5 R6 R11"}, regRdata, expStatus());
    chk({tag, " txDma R9"}, {31'd0, txDmaReq}, {31'd0, mCtrl[10] & txSvc});
    chk({tag, " rxDma R9"}, {31'd0, rxDmaReq}, {31'd0, mCtrl[11] & rxSvc});
    chk({tag, " irq R10"}, {31'd0, irq}, {31'd0, irqE});
    @(posedge clk); #1;
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    regAddr = a; regWr = 1'b1; regWdata = d;
    case (a)
      2'd0: mCtrl = d[11:0];
      2'd1: mIen = {d[6:1], 1'b0};
      2'd2: if (txQ.size() < 32) txQ.push_back(d);
      default: begin
        if (d[12]) mTur = 1'b0;
        if (d[20]) mRor = 1'b0;
        if (d[21]) mBce = 1'b0;
      end
    endcase
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic busPopRx();
    regAddr = 2'd2; regRd = 1'b1;
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic engPull();
    engTxPop = 1'b1;
    if (txQ.size() == 0) mTur = 1'b1;
    @(posedge clk); #1;
    engTxPop = 1'b0;
  endtask

  task automatic engPush(logic [31:0] d);
    engRxPush = 1'b1; engRxData = d;
    if (rxQ.size() < 32) rxQ.push_back(d); else mRor = 1'b1;
    @(posedge clk); #1;
    engRxPush = 1'b0;
  endtask

  task automatic readReg(logic [1:0] a, logic [31:0] exp, string tag);
    regAddr = a;
    @(negedge clk);
    chk(tag, regRdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    readReg(2'd0, 32'h0, "R1 ctrl after reset");
    readReg(2'd1, 32'h0, "R1 enables after reset");
    readReg(2'd3, 32'h40, "R1 status after reset");
    checkAll("R1");

    // R8 watermark codes and DMA enables
    busWrite(2'd0, 32'h0000_0C6F);
    readReg(2'd0, 32'h0000_0C6F, "R8 ctrl readback");
    checkAll("R8 empty tx");

    // R2/R4/R9 fill transmit FIFO across the watermark
    for (int i = 0; i < 16; i++) busWrite(2'd2, 32'hA000_0000 + i);
    checkAll("R9 free16");
    busWrite(2'd2, 32'hA000_0010);
    checkAll("R9 free15");
    for (int i = 17; i < 32; i++) busWrite(2'd2, 32'hA000_0000 + i);
    checkAll("R4 tx full");
    busWrite(2'd2, 32'hDEAD_BEEF);
    checkAll("R2 dropped write");
    for (int i = 0; i < 32; i++) engPull();
    checkAll("R4 tx drained");

    // R6 underrun set, hold, clear, set-wins
    engPull();
    checkAll("R6 underrun");
    busWrite(2'd3, 32'h0);
    checkAll("R6 zero write keeps");
    busWrite(2'd3, 32'h0000_1000);
    checkAll("R6 cleared");
    regAddr = 2'd3; regWr = 1'b1; regWdata = 32'h0000_1000; engTxPop = 1'b1;
    mTur = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0; engTxPop = 1'b0;
    checkAll("R6 set wins");

    // R5/R8/R9 receive watermark
    for (int i = 0; i < 3; i++) engPush(32'h5500_0000 + i);
    checkAll("R5 three");
    engPush(32'h5500_0003);
    checkAll("R9 rx mark");
    busPopRx();
    busPopRx();
    for (int i = 4; i < 34; i++) engPush(32'h5500_0000 + i);
    checkAll("R5 rx full");
    engPush(32'h6600_0000);
    checkAll("R6 overrun");

    // R7 simultaneous push and pop on a full FIFO
    busWrite(2'd3, 32'h0010_0000);
    regAddr = 2'd2; regRd = 1'b1; engRxPush = 1'b1; engRxData = 32'h7700_0001;
    @(negedge clk);
    rxQ.push_back(32'h7700_0001);
    @(posedge clk); #1;
    regRd = 1'b0; engRxPush = 1'b0;
    checkAll("R7 push and pop");
    for (int i = 0; i < 32; i++) busPopRx();
    checkAll("R3 rx drained");
    busPopRx();
    checkAll("R3 empty read");

    // R10 interrupt sources
    busWrite(2'd1, 32'h0000_0004);
    checkAll("R10 rx svc off");
    busWrite(2'd1, 32'h0000_0020);
    checkAll("R10 underrun on");
    busWrite(2'd1, 32'h0000_0002);
    engRxTimeout = 1'b1;
    checkAll("R10 timeout on");
    engRxTimeout = 1'b0;
    checkAll("R10 timeout off");
    busWrite(2'd1, 32'h0000_0008);
    checkAll("R10 tx svc");
    engBitErr = 1'b1; mBce = 1'b1;
    @(posedge clk); #1;
    engBitErr = 1'b0;
    busWrite(2'd1, 32'h0000_0040);
    checkAll("R10 bit error");
    busWrite(2'd3, 32'hFFFF_FFFF);
    checkAll("R6 clear all");
    busWrite(2'd1, 32'h0000_0010);
    checkAll("R10 overrun off");

    // R11 busy mirror
    engBusy = 1'b1;
    checkAll("R11 busy");
    engBusy = 1'b0;
    checkAll("R11 idle");

    finishRun();
  end

endmodule